// File: doc/BRIEF.md
# SPI Master Engine with Programmable Chip-Select Timing

This block is a single-channel SPI master that runs entirely on the system clock. A host-side register layer presents a transmit word with a one-cycle start strobe. The engine latches the word and its per-transfer settings, drives chip select low and waits a programmed number of system-clock cycles. It then checks an active-low slave-ready input and produces the serial clock. It shifts the word out most-significant bit first while collecting the incoming bits. After the last serial clock edge it keeps chip select low for a second programmed interval, then returns the received word with a one-cycle done pulse.

All settings are latched on the cycle the start strobe is accepted: clock polarity, clock phase, half-period length, CS-hold mode and the two delay counts. Changes made to them during a transfer do not affect it. The serial clock half period is a whole number of system-clock cycles, so the full period ranges from 2 to 256 cycles with a 50% duty cycle.

Top module: `spi_dly_master`

## Requirements
- R1: While reset is held, csN is 1, sclk is 0, mosi is 0, busy is 0, done is 0 and rxWord is 0.
- R2: A start strobe that is sampled high on edge S while the engine is idle sets busy after edge S and drives csN low after edge S+1 (call that edge C).
- R3: slaveRdyN is first sampled on edge C+c2tCfg+1. If it is high there, it is sampled again on every following edge, and no serial clock edge occurs until it has been seen low (on edge s).
- R4: With cpha=0, the first serial clock edge happens on edge s+1 when csHold=0 and on edge s+2 when csHold=1. With no stall this is C+c2tCfg+2 or C+c2tCfg+3.
- R5: With cpha=1, the first serial clock edge comes H edges later than the cpha=0 case, where H = halfCfg+1.
- R6: sclk changes to the latched cpol on edge S. It then toggles exactly 2*W times, H edges apart, and ends at cpol, so its period is 2*H and its duty cycle is 50%.
- R7: mosi carries txWord MSB first. With cpha=0 the MSB is present before the first serial edge and the next bit is launched on every second, fourth, ... edge except the last. With cpha=1 the next bit is launched on the third, fifth, ... edges.
- R8: miso is captured on the odd-numbered serial edges (first, third, ...) when cpha=0 and on the even-numbered edges when cpha=1. The W captured bits, first capture in the MSB, appear on rxWord after the edge where done rises and stay there until the next transfer ends.
- R9: Let L be the last serial edge. csN returns to 1 on edge L+t2cCfg+1+H when cpha=0 and on edge L+t2cCfg+1 when cpha=1.
- R10: done is high for exactly one cycle, on the same edge where csN returns high.
- R11: busy falls on the edge where done rises. A start strobe, or a change to any setting input, while busy is high has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle request to begin a transfer |
| txWord | input | W | Word to send |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: capture on leading edge; 1: launch on leading edge |
| csHold | input | 1 | Adds one cycle before the first serial edge |
| halfCfg | input | DIVW | Serial clock half period minus one, in system cycles |
| c2tCfg | input | DLYW | Chip-select-to-clock delay count |
| t2cCfg | input | DLYW | Clock-to-chip-select delay count |
| slaveRdyN | input | 1 | Active-low slave-ready |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| csN | output | 1 | Active-low chip select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rxWord | output | W | Word received in the last transfer |

## Verification
The assertions assume that startReq, slaveRdyN and miso are synchronous to clk, and that the setting inputs are only meaningful on the cycle a start is accepted. The stimulus changes every input on the falling clock edge. It drives miso as a slave would, presenting the next bit after each capture edge. It holds slaveRdyN high past its first sample point and then releases it, to exercise the stall. In one transfer it pulses startReq and flips every setting while the transfer is running, to show that the running transfer keeps its latched values.

// File: rtl/spi_dly_pkg.sv
package spi_dly_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SETUP,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL
  } ctrlState_t;

  typedef struct packed {
    logic accept;
    logic toggle;
    logic launch;
    logic capture;
    logic finish;
  } shiftStb_t;

endpackage

// File: rtl/spi_dly_ctrl.sv
module spi_dly_ctrl
  import spi_dly_pkg::*;
#(
  parameter int W    = 8,
  parameter int DIVW = 7,
  parameter int DLYW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            cpha,
  input  logic            csHold,
  input  logic [DIVW-1:0] halfCfg,
  input  logic [DLYW-1:0] c2tCfg,
  input  logic [DLYW-1:0] t2cCfg,
  input  logic            slaveRdyN,
  output shiftStb_t       stb,
  output logic            csN,
  output logic            busy,
  output logic            done
);

  localparam int IDXW = $clog2(2 * W) + 1;
  localparam int CNTW = ((DLYW > DIVW) ? DLYW : DIVW) + 2;
  localparam logic [IDXW-1:0] LASTIDX = IDXW'(2 * W - 1);

  ctrlState_t      state;
  logic [CNTW-1:0] cnt;
  logic [IDXW-1:0] edgeIdx;
  logic [IDXW-1:0] curIdx;
  logic            cphaL;
  logic            holdL;
  logic [DIVW-1:0] halfL;
  logic [DLYW-1:0] c2tL;
  logic [DLYW-1:0] t2cL;
  logic [CNTW-1:0] halfLen;
  logic [CNTW-1:0] leadLen;
  logic [CNTW-1:0] tailLen;

  assign halfLen = CNTW'(halfL) + CNTW'(1);
  assign leadLen = CNTW'(holdL) + (cphaL ? halfLen : '0);
  assign tailLen = CNTW'(t2cL) + (cphaL ? '0 : halfLen);

  always_comb begin
    curIdx      = (state == ST_LEAD) ? '0 : edgeIdx;
    stb         = '0;
    stb.accept  = (state == ST_IDLE) && startReq;
    stb.toggle  = ((state == ST_LEAD) || (state == ST_SHIFT)) && (cnt == '0);
    stb.capture = stb.toggle && (curIdx[0] == cphaL);
    stb.launch  = stb.toggle && (curIdx[0] != cphaL) &&
                  (cphaL ? (curIdx != '0) : (curIdx != LASTIDX));
    stb.finish  = (state == ST_TAIL) && (cnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      edgeIdx <= '0;
      csN     <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      cphaL   <= 1'b0;
      holdL   <= 1'b0;
      halfL   <= '0;
      c2tL    <= '0;
      t2cL    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            cphaL <= cpha;
            holdL <= csHold;
            halfL <= halfCfg;
            c2tL  <= c2tCfg;
            t2cL  <= t2cCfg;
            busy  <= 1'b1;
            state <= ST_ARM;
          end
        end
        ST_ARM: begin
          csN   <= 1'b0;
          cnt   <= CNTW'(c2tL);
          state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (!slaveRdyN) begin
            cnt   <= leadLen;
            state <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (cnt == '0) begin
            cnt     <= halfLen - 1'b1;
            edgeIdx <= IDXW'(1);
            state   <= ST_SHIFT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SHIFT: begin
          if (cnt == '0) begin
            edgeIdx <= edgeIdx + 1'b1;
            if (edgeIdx == LASTIDX) begin
              cnt   <= tailLen;
              state <= ST_TAIL;
            end else begin
              cnt <= halfLen - 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TAIL: begin
          if (cnt == '0) begin
            csN   <= 1'b1;
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a high ready sample at the decision point keeps the engine waiting with CS low
  a_r3_wait_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP && cnt == '0 && slaveRdyN) |=> (state == ST_SETUP && !csN));

  // R11: a start request while busy leaves the state machine running
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && state != ST_TAIL && startReq) |=> busy);

endmodule

// File: rtl/spi_dly_dpath.sv
module spi_dly_dpath
  import spi_dly_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  shiftStb_t    stb,
  input  logic         cpol,
  input  logic [W-1:0] txWord,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic [W-1:0] rxWord
);

  logic [W-1:0] txShift;
  logic [W-1:0] rxShift;

  assign mosi = txShift[W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      sclk    <= 1'b0;
      rxWord  <= '0;
    end else begin
      if (stb.accept) begin
        txShift <= txWord;
        rxShift <= '0;
        sclk    <= cpol;
      end else begin
        if (stb.toggle)  sclk    <= ~sclk;
        if (stb.launch)  txShift <= {txShift[W-2:0], 1'b0};
        if (stb.capture) rxShift <= {rxShift[W-2:0], miso};
        if (stb.finish)  rxWord  <= rxShift;
      end
    end
  end

  // R7: serial output only moves on a launch edge or when a new word is taken
  a_r7_mosi_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.launch && !stb.accept) |=> $stable(mosi));

  // R8: the received word only updates at the end of a transfer
  a_r8_rx_held: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finish |=> $stable(rxWord));

endmodule

// File: rtl/spi_dly_master.sv
module spi_dly_master
  import spi_dly_pkg::*;
#(
  parameter int W    = 8,
  parameter int DIVW = 7,
  parameter int DLYW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic [W-1:0]    txWord,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            csHold,
  input  logic [DIVW-1:0] halfCfg,
  input  logic [DLYW-1:0] c2tCfg,
  input  logic [DLYW-1:0] t2cCfg,
  input  logic            slaveRdyN,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            csN,
  output logic            busy,
  output logic            done,
  output logic [W-1:0]    rxWord
);

  shiftStb_t stb;

  spi_dly_ctrl #(.W(W), .DIVW(DIVW), .DLYW(DLYW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .cpha      (cpha),
    .csHold    (csHold),
    .halfCfg   (halfCfg),
    .c2tCfg    (c2tCfg),
    .t2cCfg    (t2cCfg),
    .slaveRdyN (slaveRdyN),
    .stb       (stb),
    .csN       (csN),
    .busy      (busy),
    .done      (done)
  );

  spi_dly_dpath #(.W(W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .cpol   (cpol),
    .txWord (txWord),
    .miso   (miso),
    .sclk   (sclk),
    .mosi   (mosi),
    .rxWord (rxWord)
  );

  // R2: chip select is only active inside a busy window
  a_r2_cs_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy);

  // R9: the done pulse coincides with chip select released
  a_r9_cs_released: assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN);

  // R10: done lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: busy only drops together with done
  a_r11_busy_ends: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R6: the serial clock is quiet while no transfer is running
  a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(sclk));

endmodule

// File: tb/sim_spi_dly_master.sv
module sim_spi_dly_master;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;
  localparam int DIVW = 7;
  localparam int DLYW = 8;

  logic            clk = 1'b0;
  logic            rstN;
  logic            startReq;
  logic [W-1:0]    txWord;
  logic            cpol, cpha, csHold;
  logic [DIVW-1:0] halfCfg;
  logic [DLYW-1:0] c2tCfg, t2cCfg;
  logic            slaveRdyN;
  logic            miso;
  logic            sclk, mosi, csN, busy, done;
  logic [W-1:0]    rxWord;

  spi_dly_master #(.W(W), .DIVW(DIVW), .DLYW(DLYW)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .txWord(txWord),
    .cpol(cpol), .cpha(cpha), .csHold(csHold), .halfCfg(halfCfg),
    .c2tCfg(c2tCfg), .t2cCfg(t2cCfg), .slaveRdyN(slaveRdyN), .miso(miso),
    .sclk(sclk), .mosi(mosi), .csN(csN), .busy(busy), .done(done),
    .rxWord(rxWord)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nRun = 0;
  int nFail = 0;
  bit chkOn = 1'b0;

  // reference model state for the current transfer
  int gS = -1, gC = -1, gE = -1, gF = 1 << 30, gH = 1, gBase = 0;
  int gCpha = 0;
  int gCpol = 0;
  int idleLvl = 0;
  logic [W-1:0] txT = '0, rxT = '0, prevRx = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  function automatic int toggles(int n);
    int t;
    if (n < gF) return 0;
    t = (n - gF) / gH + 1;
    return (t > 2 * W) ? 2 * W : t;
  endfunction

  function automatic int countIdx(int n, int parity, int lo, int hi);
    int c = 0;
    for (int i = lo; i <= hi; i++)
      if ((i % 2) == parity && gF + i * gH <= n) c++;
    return c;
  endfunction

  function automatic int launches(int n);
    return (gCpha == 0) ? countIdx(n, 1, 1, 2 * W - 3) : countIdx(n, 0, 2, 2 * W - 2);
  endfunction

  // compare every output each cycle, away from the active edge
  always @(negedge clk) begin
    if (chkOn) begin
      logic expCs, expBusy, expDone, expSclk;
      logic [W-1:0] expRx;
      expCs   = !(cyc >= gC && cyc < gE);
      expBusy = (cyc >= gS && cyc < gE);
      expDone = (cyc == gE);
      expSclk = (cyc >= gS) ? 1'(gCpol ^ (toggles(cyc) & 1)) : 1'(idleLvl);
      expRx   = (cyc >= gE) ? rxT : prevRx;
      chk(csN == expCs, "R2 R4 R9 csN", csN, expCs);
      chk(busy == expBusy, "R11 busy", busy, expBusy);
      chk(done == expDone, "R10 done", done, expDone);
      chk(sclk == expSclk, "R3 R4 R5 R6 sclk", sclk, expSclk);
      chk(rxWord == expRx, "R8 rxWord", rxWord, expRx);
      if (!expCs) begin
        logic expMosi;
        expMosi = txT[W - 1 - launches(cyc)];
        chk(mosi == expMosi, "R7 mosi", mosi, expMosi);
      end
    end
  end

  task automatic runXfer(input logic [W-1:0] tx, input logic [W-1:0] rx,
                         input int pol, input int pha, input int hold,
                         input int half, input int c2t, input int t2c,
                         input int rdyDelay, input bit disturb);
    int s, L, caps;
    @(negedge clk);
    idleLvl = gCpol;
    prevRx  = rxT;
    txWord  = tx;
    cpol    = 1'(pol);
    cpha    = 1'(pha);
    csHold  = 1'(hold);
    halfCfg = DIVW'(half);
    c2tCfg  = DLYW'(c2t);
    t2cCfg  = DLYW'(t2c);
    slaveRdyN = (rdyDelay > 0);
    startReq = 1'b1;
    gS = cyc + 1;
    gC = gS + 1;
    gBase = gC + c2t + 1;
    s = gBase + rdyDelay;
    gH = half + 1;
    gF = s + 1 + hold + ((pha != 0) ? gH : 0);
    L = gF + (2 * W - 1) * gH;
    gE = L + 1 + t2c + ((pha != 0) ? 0 : gH);
    gCpha = pha;
    gCpol = pol;
    txT = tx;
    rxT = rx;
    while (cyc <= gE + 1) begin
      @(negedge clk);
      startReq = disturb && (cyc == gC + 3);
      if (disturb && cyc == gC + 3) begin
        // R11: new request and new settings mid-transfer must not matter
        txWord  = ~tx;
        cpol    = ~cpol;
        cpha    = ~cpha;
        csHold  = ~csHold;
        halfCfg = '0;
        c2tCfg  = 8'd9;
        t2cCfg  = 8'd9;
      end
      if (rdyDelay > 0) slaveRdyN = (cyc < gBase + rdyDelay - 1);
      caps = countIdx(cyc, pha, 0, 2 * W - 1);
      miso = (caps < W) ? rx[W - 1 - caps] : 1'b0;
    end
    miso = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    startReq = 1'b0;
    txWord = '0;
    cpol = 1'b0; cpha = 1'b0; csHold = 1'b0;
    halfCfg = '0; c2tCfg = '0; t2cCfg = '0;
    slaveRdyN = 1'b0;
    miso = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(csN == 1'b1, "R1 csN", csN, 1);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(mosi == 1'b0, "R1 mosi", mosi, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(rxWord == '0, "R1 rxWord", rxWord, 0);
    rstN = 1'b1;
    chkOn = 1'b1;
    repeat (2) @(negedge clk);

    // R4: phase 0, no CS hold, shortest delays
    runXfer(8'hA5, 8'h3C, 0, 0, 0, 1, 0, 0, 0, 0);
    // R4: phase 0 with CS hold, idle-high clock, fastest clock
    runXfer(8'h96, 8'hE1, 1, 0, 1, 0, 3, 2, 0, 0);
    // R5: phase 1 adds half a period before the first edge
    runXfer(8'h4B, 8'h81, 0, 1, 0, 2, 1, 4, 0, 0);
    // R3: slave not ready for six extra samples
    runXfer(8'hC3, 8'h5A, 1, 1, 1, 3, 5, 0, 6, 0);
    // R11: start strobe and setting changes while busy
    runXfer(8'h0F, 8'hF0, 0, 0, 0, 1, 2, 1, 0, 1);
    // R6 R9: longest period and longest delays
    runXfer(8'hFF, 8'h01, 1, 1, 0, 127, 255, 255, 0, 0);
    // R3: one-cycle stall in phase 0 with hold
    runXfer(8'h80, 8'h7E, 0, 0, 1, 0, 0, 3, 1, 0);

    chkOn = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule